// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block times the SCL clock of an I2C master. A reference tick is made by dividing the input clock by a power of two chosen by a 3-bit prescaler select. Two 5-bit counts then set how many reference periods the SCL low phase and the SCL high phase last. Each phase also carries a fixed overhead that stands for the synchronization and noise-filter delay. That overhead is one period larger when the prescaler is bypassed. The block drives a request to pull SCL low. It also gives the byte engine one pulse in the middle of each high phase, so that the engine can sample SDA there.

The high phase is counted only after the filtered SCL line has been seen high. A slave that holds SCL low therefore stretches the clock for as long as it likes. The filter takes SCL through a synchronizer. It then accepts a new level only when two reference-tick samples in a row agree, so a pulse that lasts one reference period is dropped. The generator runs while the controller is enabled, is not held in internal reset, and the byte engine asks for clocks. In any other case it stops at once with SCL released.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, SCL is released and no mid tick is given. The mode register reads 0x00, and both count registers read 0xFF.
- R2: The reference tick comes every 2^S input clock cycles, where S is the prescaler select. A select of 7 acts as 6. With S = 0 there is a tick on every active cycle.
- R3: The mode register is at address 0, with the prescaler select in bits 6:4. The select changes only when bit 3 of the same write is 1. A write with bit 3 at 0 leaves the select as it was.
- R4: The low count is at address 1 and the high count at address 2, each held in bits 4:0. When read, bits 7:5 of these registers are 1. The mode register reads back its select in bits 6:4, and its other bits read 0.
- R5: A low phase drives SCL low for (N + K + 1) × 2^S input cycles. N is the low count and K is the overhead: 3 when S = 0 and 2 otherwise.
- R6: The high phase lasts H = (N + K + 1) reference periods, counted once SCL is seen high, where N is the high count. The mid tick is a single-cycle pulse while SCL is released. The next low phase starts floor(H/2) × 2^S cycles after the mid tick.
- R7: A count value of 0 acts as 1.
- R8: While SCL is held low from outside during the high phase, no mid tick is given and SCL stays released, however long the hold lasts.
- R9: During such a hold, a high pulse on SCL that lasts one reference period does not start the high count.
- R10: Clearing the enable, raising the internal-reset hold or dropping the run request releases SCL on the next cycle and stops the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 low count, 2 high count |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| ctrl_en | input | 1 | Controller enable |
| ctrl_rst_hold | input | 1 | Internal reset hold; stops the generator |
| run | input | 1 | Clock request from the byte engine |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | Request to pull SCL low |
| bit_mid_tick | output | 1 | One-cycle pulse in the middle of the high phase |

## Verification
The low-phase width and the delay from the mid tick to the next low phase are measured for fixed and seeded random prescaler and count settings. The directed settings include the bypassed prescaler with its larger overhead, zero counts, the largest counts and the out-of-range select. These measurements separate a wrong divider, a wrong overhead or a wrong clamp from correct phase timing. A second pattern holds SCL low from the slave side, adds a one-period glitch, and then releases the line. This shows whether the high phase waits for the real line level and ignores the glitch. Write-protected writes and reserved bits are checked at the read port. The enable, internal-reset hold and run inputs are each dropped in the middle of a phase.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    localparam int REG_W    = 8;
    localparam int CNT_W    = 5;
    localparam int PRE_W    = 3;
    localparam int PRE_MAX  = 6;
    localparam int OVH_BYP  = 3;
    localparam int OVH_DIV  = 2;
    localparam int LEN_W    = CNT_W + 1;
    localparam int DIV_W    = (1 << PRE_W) - 1;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_LOW  = 2'd1;
    localparam logic [1:0] ADDR_HIGH = 2'd2;
    localparam int WP_BIT  = 3;
    localparam int SEL_LSB = 4;

    typedef logic [LEN_W-1:0] len_t;
    typedef logic [DIV_W-1:0] div_t;
    typedef logic [PRE_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOW   = 2'd1,
        PH_HWAIT = 2'd2,
        PH_HCNT  = 2'd3
    } phase_e;

    typedef struct packed {
        sel_t sel;
        cnt_t lo;
        cnt_t hi;
    } timing_cfg_t;

    function automatic sel_t clamp_sel(input sel_t s);
        return (s > sel_t'(PRE_MAX)) ? sel_t'(PRE_MAX) : s;
    endfunction

    function automatic div_t div_m1(input sel_t s);
        return (div_t'(1) << s) - div_t'(1);
    endfunction

    function automatic len_t phase_len(input cnt_t n, input sel_t s);
        cnt_t eff;
        eff = (n == '0) ? cnt_t'(1) : n;
        return len_t'(eff) + ((s == '0) ? len_t'(OVH_BYP + 1) : len_t'(OVH_DIV + 1));
    endfunction

endpackage

// File: rtl/scl_rate_regs.sv
module scl_rate_regs
    import scl_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output timing_cfg_t      cfg,
    output sel_t             raw_sel
);

    sel_t sel_q;
    cnt_t lo_q;
    cnt_t hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            lo_q  <= '1;
            hi_q  <= '1;
        end else if (we) begin
            case (addr)
                ADDR_MODE: if (wdata[WP_BIT]) sel_q <= wdata[SEL_LSB +: PRE_W];
                ADDR_LOW:  lo_q <= wdata[CNT_W-1:0];
                ADDR_HIGH: hi_q <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_MODE: rdata[SEL_LSB +: PRE_W] = sel_q;
            ADDR_LOW:  rdata = {{(REG_W-CNT_W){1'b1}}, lo_q};
            ADDR_HIGH: rdata = {{(REG_W-CNT_W){1'b1}}, hi_q};
            default:   rdata = '0;
        endcase
    end

    assign cfg.sel = clamp_sel(sel_q);
    assign cfg.lo  = lo_q;
    assign cfg.hi  = hi_q;
    assign raw_sel = sel_q;

endmodule

// File: rtl/scl_rate_prescale.sv
module scl_rate_prescale
    import scl_rate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  sel_t sel,
    output logic ref_tick
);

    div_t pre_q;
    div_t limit;

    assign limit    = div_m1(sel);
    assign ref_tick = active && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pre_q <= '0;
        end else if (ref_tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + div_t'(1);
        end
    end

endmodule

// File: rtl/scl_rate_filter.sv
module scl_rate_filter #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic line_in,
    output logic line_filt
);

    logic [STAGES-1:0] sync_q;
    logic              hist_q;
    logic              filt_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[g] <= 1'b1;
                end else if (g == 0) begin
                    sync_q[g] <= line_in;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 1'b1;
            filt_q <= 1'b1;
        end else if (ref_tick) begin
            hist_q <= sync_q[STAGES-1];
            if (sync_q[STAGES-1] == hist_q) filt_q <= sync_q[STAGES-1];
        end
    end

    assign line_filt = filt_q;

endmodule

// File: rtl/scl_rate_phase.sv
module scl_rate_phase
    import scl_rate_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  logic   ref_tick,
    input  logic   line_filt,
    input  len_t   low_len,
    input  len_t   high_len,
    output logic   drive_low,
    output logic   mid_tick,
    output phase_e state
);

    phase_e st_q;
    len_t   cnt_q;
    len_t   half_q;
    logic   mid_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            st_q   <= PH_IDLE;
            cnt_q  <= '0;
            half_q <= '0;
            mid_q  <= 1'b0;
        end else begin
            mid_q <= 1'b0;
            if (ref_tick) begin
                case (st_q)
                    PH_IDLE: begin
                        st_q  <= PH_LOW;
                        cnt_q <= low_len - len_t'(1);
                    end
                    PH_LOW: begin
                        if (cnt_q == '0) st_q <= PH_HWAIT;
                        else             cnt_q <= cnt_q - len_t'(1);
                    end
                    PH_HWAIT: begin
                        if (line_filt) begin
                            st_q   <= PH_HCNT;
                            cnt_q  <= high_len - len_t'(1);
                            half_q <= high_len >> 1;
                        end
                    end
                    PH_HCNT: begin
                        if (cnt_q == half_q) mid_q <= 1'b1;
                        if (cnt_q == '0) begin
                            st_q  <= PH_LOW;
                            cnt_q <= low_len - len_t'(1);
                        end else begin
                            cnt_q <= cnt_q - len_t'(1);
                        end
                    end
                    default: st_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign drive_low = (st_q == PH_LOW);
    assign mid_tick  = mid_q;
    assign state     = st_q;

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_rate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ctrl_en,
    input  logic       ctrl_rst_hold,
    input  logic       run,
    input  logic       scl_in,
    output logic       scl_drive_low,
    output logic       bit_mid_tick
);

    timing_cfg_t cfg;
    sel_t        raw_sel;
    logic        active;
    logic        ref_tick;
    logic        scl_filt;
    len_t        low_len;
    len_t        high_len;
    phase_e      phase_st;

    assign active   = ctrl_en && !ctrl_rst_hold && run;
    assign low_len  = phase_len(cfg.lo, cfg.sel);
    assign high_len = phase_len(cfg.hi, cfg.sel);

    scl_rate_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .cfg     (cfg),
        .raw_sel (raw_sel)
    );

    scl_rate_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .sel      (cfg.sel),
        .ref_tick (ref_tick)
    );

    scl_rate_filter #(.STAGES(2)) u_filt (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .line_in   (scl_in),
        .line_filt (scl_filt)
    );

    scl_rate_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .ref_tick  (ref_tick),
        .line_filt (scl_filt),
        .low_len   (low_len),
        .high_len  (high_len),
        .drive_low (scl_drive_low),
        .mid_tick  (bit_mid_tick),
        .state     (phase_st)
    );

endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk
    import scl_rate_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       active,
    input logic       ref_tick,
    input sel_t       sel_eff,
    input sel_t       raw_sel,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input phase_e     phase_st,
    input logic       scl_drive_low,
    input logic       bit_mid_tick
);

    assert_bypass_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (active && sel_eff == '0) |-> ref_tick);

    assert_wp_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_MODE && !reg_wdata[WP_BIT]) |=> $stable(raw_sel));

    assert_low_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_drive_low) |-> $past(ref_tick));

    assert_mid_single_R6: assert property (@(posedge clk) disable iff (rst)
        bit_mid_tick |=> !bit_mid_tick);

    assert_mid_released_R6: assert property (@(posedge clk) disable iff (rst)
        bit_mid_tick |-> !scl_drive_low);

    assert_no_mid_waiting_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_st == PH_HWAIT) |=> !bit_mid_tick);

    assert_off_released_R10: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!scl_drive_low && !bit_mid_tick));

endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .active        (active),
    .ref_tick      (ref_tick),
    .sel_eff       (cfg.sel),
    .raw_sel       (raw_sel),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .phase_st      (phase_st),
    .scl_drive_low (scl_drive_low),
    .bit_mid_tick  (bit_mid_tick)
);

// File: tb/scl_rate_gen_tb.sv
`timescale 1ns/1ps
module scl_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ctrl_en = 1'b1;
    logic       ctrl_rst_hold = 1'b0;
    logic       run = 1'b0;
    logic       slave_hold = 1'b0;
    logic       glitch = 1'b0;
    logic       scl_line;
    logic       scl_drive_low;
    logic       bit_mid_tick;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign scl_line = glitch | (!scl_drive_low && !slave_hold);

    scl_rate_gen dut_i (
        .clk           (clk),
        .rst           (rst),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ctrl_en       (ctrl_en),
        .ctrl_rst_hold (ctrl_rst_hold),
        .run           (run),
        .scl_in        (scl_line),
        .scl_drive_low (scl_drive_low),
        .bit_mid_tick  (bit_mid_tick)
    );

    function automatic int e_div(input int s);
        return 1 << ((s > 6) ? 6 : s);
    endfunction

    function automatic int e_len(input int n, input int s);
        return ((n == 0) ? 1 : n) + ((s == 0) ? 3 : 2) + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        v = int'(reg_rdata);
    endtask

    task automatic wait_low_rise(output bit ok);
        int n;
        n = 0;
        ok = 1'b0;
        while (n < 20000) begin
            @(negedge clk);
            if (scl_drive_low) begin ok = 1'b1; break; end
            n++;
        end
    endtask

    task automatic measure_low(output int w);
        w = 0;
        while (scl_drive_low && w < 20000) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic measure_mid(output int k);
        int n;
        n = 0;
        k = -1;
        while (!bit_mid_tick && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (bit_mid_tick) begin
            k = 0;
            do begin
                @(negedge clk);
                k++;
            end while (!scl_drive_low && k < 20000);
        end
    endtask

    // R2 R5 R6 R7 R10 on one setting
    task automatic run_cfg(input int sel, input int lo, input int hi, input string tag);
        bit ok;
        int w;
        int k;
        int exp_w;
        int exp_k;
        exp_w = e_len(lo, sel) * e_div(sel);
        exp_k = (e_len(hi, sel) / 2) * e_div(sel);
        wr(2'd0, 8'((sel << 4) | 8));
        wr(2'd1, 8'(lo));
        wr(2'd2, 8'(hi));
        run = 1'b1;
        wait_low_rise(ok);
        chk(ok, {tag, " R5 low start"}, int'(ok), 1);
        measure_low(w);
        chk(w == exp_w, {tag, " R5 low width"}, w, exp_w);
        measure_mid(k);
        chk(k == exp_k, {tag, " R6 mid to low"}, k, exp_k);
        measure_low(w);
        chk(w == exp_w, {tag, " R5 second low width"}, w, exp_w);
        run = 1'b0;
        @(negedge clk);
        chk(!scl_drive_low, {tag, " R10 run drop"}, int'(scl_drive_low), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        int seed_dummy;
        bit ok;
        int w;
        int k;
        int hits;
        seed_dummy = int'($urandom(32'd24601));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!scl_drive_low, "R1 released", int'(scl_drive_low), 0);
        chk(!bit_mid_tick, "R1 no tick", int'(bit_mid_tick), 0);
        rd(2'd0, v); chk(v == 8'h00, "R1 mode", v, 8'h00);
        rd(2'd1, v); chk(v == 8'hFF, "R1 low", v, 8'hFF);
        rd(2'd2, v); chk(v == 8'hFF, "R1 high", v, 8'hFF);

        // R4 reserved bits
        wr(2'd1, 8'h0A); rd(2'd1, v); chk(v == 8'hEA, "R4 low readback", v, 8'hEA);
        wr(2'd2, 8'h13); rd(2'd2, v); chk(v == 8'hF3, "R4 high readback", v, 8'hF3);

        // R3 write protect
        wr(2'd0, 8'h28); rd(2'd0, v); chk(v == 8'h20, "R3 enabled write", v, 8'h20);
        wr(2'd0, 8'h50); rd(2'd0, v); chk(v == 8'h20, "R3 protected write", v, 8'h20);
        wr(2'd0, 8'h58); rd(2'd0, v); chk(v == 8'h50, "R3 second enabled write", v, 8'h50);

        // directed timing corners
        run_cfg(0, 1, 1, "R5 bypass min");
        run_cfg(1, 1, 1, "R2 div2 min");
        run_cfg(1, 0, 0, "R7 zero counts");
        run_cfg(7, 1, 2, "R2 select7");
        run_cfg(0, 31, 31, "R5 bypass max");
        run_cfg(2, 31, 0, "R7 zero high");

        // random settings
        for (int i = 0; i < 12; i++) begin
            run_cfg(int'($urandom % 5), int'($urandom % 32), int'($urandom % 32), "R6 random");
        end

        // R8 stretch and R9 glitch
        wr(2'd0, 8'h08); wr(2'd1, 8'd1); wr(2'd2, 8'd1);
        run = 1'b1;
        wait_low_rise(ok);
        slave_hold = 1'b1;
        measure_low(w);
        chk(w == 5, "R5 low before stretch", w, 5);
        hits = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (scl_drive_low || bit_mid_tick) hits++;
        end
        chk(hits == 0, "R8 stretched no activity", hits, 0);
        glitch = 1'b1;
        @(negedge clk);
        glitch = 1'b0;
        hits = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (scl_drive_low || bit_mid_tick) hits++;
        end
        chk(hits == 0, "R9 glitch ignored", hits, 0);
        slave_hold = 1'b0;
        measure_mid(k);
        chk(k == 2, "R8 resume after stretch", k, 2);
        run = 1'b0;
        repeat (3) @(negedge clk);

        // R10 enable and internal reset hold
        wr(2'd0, 8'h38); wr(2'd1, 8'd20); wr(2'd2, 8'd20);
        run = 1'b1;
        wait_low_rise(ok);
        ctrl_en = 1'b0;
        @(negedge clk);
        chk(!scl_drive_low, "R10 enable drop", int'(scl_drive_low), 0);
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (scl_drive_low || bit_mid_tick) hits++;
        end
        chk(hits == 0, "R10 disabled quiet", hits, 0);
        ctrl_en = 1'b1;
        wait_low_rise(ok);
        ctrl_rst_hold = 1'b1;
        @(negedge clk);
        chk(!scl_drive_low, "R10 reset hold", int'(scl_drive_low), 0);
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (scl_drive_low || bit_mid_tick) hits++;
        end
        chk(hits == 0, "R10 held quiet", hits, 0);
        ctrl_rst_hold = 1'b0;
        run = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule